// File: doc/BRIEF.md
# Watchdog Lockup Recovery Controller

This block takes the timeout pulse of a hardware watchdog and runs the system's recovery after a lockup. A static policy input selects one of two behaviours. Under the reboot policy, the first lockup produces one alert message and one processor reboot request. If the watchdog then expires again before firmware acknowledges the recovery, the block gives up on automatic reboots and enters heartbeat mode. Under the no-reboot policy, the first lockup sends an alert and goes straight to heartbeat mode. In heartbeat mode a message request is raised once every heartbeat period.

A sticky status flag records the lockup. Firmware clears it with a one-cycle write strobe, which ends the episode and silences all further heartbeats. While in heartbeat mode, the block turns operator and management-bus interventions into one-cycle request pulses for the power sequencer: a power-button override becomes a soft-off request, a following button press becomes a wake request, and a falling power-good or a bus reset command becomes a system reset request. Heartbeats keep running through all of these interventions. Messages go to an external sender over a valid/ready handshake and carry a wrapping sequence number.

The heartbeat period is a whole number of prescaled tick pulses, set by a parameter. The real system uses a tick of about one second.

Top module: `wdt_recovery_ctrl`

## Requirements
- R1: While rst_ni is low and right after release, sts_o, msg_valid_o, msg_seq_o and all request outputs are 0.
- R2: A wdt_expire_i pulse while idle sets sts_o in the next cycle. sts_o then stays 1 through further expiries and interventions, and only a sts_clr_i strobe clears it.
- R3: Under the reboot policy (reboot_policy_i=1), the first expiry gives, in the same cycle that sts_o rises, exactly one reboot_req_o pulse and one message with msg_kind_o=0 (alert).
- R4: A sts_clr_i strobe after the reboot request and before a second expiry returns the block to idle. sts_o goes to 0 and no further messages are requested.
- R5: A second expiry after the reboot request raises a heartbeat (msg_kind_o=1) in the next cycle. From then on there is a heartbeat every HB_TICKS tick_i pulses, and no reboot_req_o is issued again in that episode, even on further expiries.
- R6: Under the no-reboot policy (reboot_policy_i=0), an expiry raises an alert message in the next cycle with no reboot_req_o, followed by a heartbeat every HB_TICKS ticks.
- R7: In heartbeat mode, pb_override_i gives one soft_off_req_o pulse, and heartbeats continue.
- R8: In heartbeat mode, pb_press_i gives one wake_req_o pulse only if an override came before it since the last wake or reset. Otherwise it is ignored.
- R9: In heartbeat mode, each falling edge of pwr_good_i and each bus_rst_cmd_i pulse gives exactly one sys_reset_req_o pulse and no reboot request.
- R10: A sts_clr_i strobe in heartbeat mode clears sts_o and stops all later heartbeats.
- R11: Each new message carries msg_seq_o equal to the previous value plus one, modulo 2^SEQ_W, starting from 0 after reset. Alerts and heartbeats share this counter.
- R12: While msg_valid_o=1 and msg_ready_i=0, the message fields hold. Any number of heartbeats that fall due during that wait merge into a single held heartbeat, sent after the pending one.
- R13: Outside heartbeat mode, override, press, power-good and bus reset events produce no request.
- R14: Every message raised during a lockup episode has msg_wd_evt_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reboot_policy_i | input | 1 | 1: one automatic reboot attempt; 0: no reboot |
| wdt_expire_i | input | 1 | Watchdog timeout pulse |
| tick_i | input | 1 | Prescaled heartbeat time base pulse |
| sts_clr_i | input | 1 | Firmware strobe that clears the lockup status |
| pb_override_i | input | 1 | Power-button override event |
| pb_press_i | input | 1 | Power-button press event |
| pwr_good_i | input | 1 | Power-good level; a falling edge is a reset event |
| bus_rst_cmd_i | input | 1 | Reset command pulse from the management bus |
| msg_ready_i | input | 1 | Message sender accepts the request |
| sts_o | output | 1 | Sticky lockup status |
| reboot_req_o | output | 1 | Processor reboot request pulse |
| soft_off_req_o | output | 1 | Soft-off request pulse |
| wake_req_o | output | 1 | Wake-to-working request pulse |
| sys_reset_req_o | output | 1 | System reset request pulse |
| msg_valid_o | output | 1 | Message request valid |
| msg_kind_o | output | 1 | 0 alert, 1 heartbeat |
| msg_wd_evt_o | output | 1 | Watchdog event status bit of the message |
| msg_seq_o | output | SEQ_W | Sequence number of the current message |

## Verification
A wrong recovery state shows at the ports within one cycle of the next stimulus. A missing or repeated reboot pulse on a later expiry, a request in answer to a button press while idle, or a heartbeat after the status clear each appear directly. A corrupt period counter shows as a wrong gap between accepted heartbeats, which the bench measures over a sweep of tick spacings. A broken pending or merge flag in the message stage shows as a skipped or repeated sequence number, or as the wrong number of handshakes once back-pressure is released.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HBEAT = 2'd2
  } wdr_state_e;

  typedef enum logic {
    MSG_ALERT = 1'b0,
    MSG_HBEAT = 1'b1
  } wdr_kind_e;
endpackage

// File: rtl/wdr_hb_timer.sv
module wdr_hb_timer #(
  parameter int HB_TICKS = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic due_o
);
  localparam int CNT_W = (HB_TICKS > 1) ? $clog2(HB_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign due_o   = run_i & tick_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdr_event_in.sv
module wdr_event_in (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_good_i,
  input  logic bus_rst_cmd_i,
  output logic rst_evt_o
);
  logic pg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_q <= 1'b1;
    else         pg_q <= pwr_good_i;
  end

  // power-good falling edge or bus command
  assign rst_evt_o = (pg_q & ~pwr_good_i) | bus_rst_cmd_i;
endmodule

// File: rtl/wdr_msg_queue.sv
module wdr_msg_queue #(
  parameter int SEQ_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alert_i,
  input  logic             hb_i,
  input  logic             flush_hb_i,
  input  logic             wd_evt_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic             kind_o,
  output logic             wd_evt_o,
  output logic [SEQ_W-1:0] seq_o
);
  import wdr_pkg::*;

  logic             valid_q, kind_q, wd_evt_q;
  logic [SEQ_W-1:0] seq_q;
  logic             owed_alert_q, owed_hb_q;
  logic             accept, free, want_alert, want_hb, load_alert, load_hb;

  always_comb begin
    accept     = valid_q & ready_i;
    free       = ~valid_q | accept;
    want_alert = owed_alert_q | alert_i;
    want_hb    = (owed_hb_q & ~flush_hb_i) | hb_i;
    load_alert = free & want_alert;
    load_hb    = free & ~want_alert & want_hb;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q      <= 1'b0;
      kind_q       <= MSG_ALERT;
      wd_evt_q     <= 1'b0;
      seq_q        <= '0;
      owed_alert_q <= 1'b0;
      owed_hb_q    <= 1'b0;
    end else begin
      if (load_alert || load_hb) begin
        valid_q  <= 1'b1;
        kind_q   <= load_hb ? MSG_HBEAT : MSG_ALERT;
        wd_evt_q <= wd_evt_i;
        seq_q    <= seq_q + 1'b1;
      end else if (accept) begin
        valid_q <= 1'b0;
      end
      owed_alert_q <= want_alert & ~load_alert;
      owed_hb_q    <= want_hb & ~load_hb;   // repeats merge into one
    end
  end

  assign valid_o  = valid_q;
  assign kind_o   = kind_q;
  assign wd_evt_o = wd_evt_q;
  assign seq_o    = seq_q;
endmodule

// File: rtl/wdr_policy_fsm.sv
module wdr_policy_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reboot_policy_i,
  input  logic expire_i,
  input  logic clr_i,
  input  logic override_i,
  input  logic press_i,
  input  logic rst_evt_i,
  input  logic due_i,
  output logic sts_o,
  output logic sts_next_o,
  output logic run_o,
  output logic alert_o,
  output logic hb_o,
  output logic flush_o,
  output logic reboot_req_o,
  output logic soft_off_req_o,
  output logic wake_req_o,
  output logic sys_reset_req_o
);
  import wdr_pkg::*;

  wdr_state_e state_q, state_d;
  logic sts_q, sts_d, soft_q, soft_d;
  logic reboot_q, reboot_d, off_q, off_d, wake_q, wake_d, sreset_q, sreset_d;

  always_comb begin
    state_d  = state_q;
    sts_d    = sts_q;
    soft_d   = soft_q;
    alert_o  = 1'b0;
    hb_o     = 1'b0;
    flush_o  = 1'b0;
    reboot_d = 1'b0;
    off_d    = 1'b0;
    wake_d   = 1'b0;
    sreset_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (expire_i) begin
          sts_d   = 1'b1;
          alert_o = 1'b1;
          if (reboot_policy_i) begin
            reboot_d = 1'b1;
            state_d  = ST_ARMED;
          end else begin
            state_d  = ST_HBEAT;
          end
        end
      end
      ST_ARMED: begin
        if (clr_i) begin
          sts_d   = 1'b0;
          state_d = ST_IDLE;
        end else if (expire_i) begin
          hb_o    = 1'b1;               // reboot failed: start heartbeats
          state_d = ST_HBEAT;
        end
      end
      ST_HBEAT: begin
        if (clr_i) begin
          sts_d   = 1'b0;
          soft_d  = 1'b0;
          flush_o = 1'b1;
          state_d = ST_IDLE;
        end else begin
          hb_o = due_i;
          if (rst_evt_i) begin
            sreset_d = 1'b1;
            soft_d   = 1'b0;
          end else if (override_i) begin
            off_d  = 1'b1;
            soft_d = 1'b1;
          end else if (press_i && soft_q) begin
            wake_d = 1'b1;
            soft_d = 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sts_q    <= 1'b0;
      soft_q   <= 1'b0;
      reboot_q <= 1'b0;
      off_q    <= 1'b0;
      wake_q   <= 1'b0;
      sreset_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sts_q    <= sts_d;
      soft_q   <= soft_d;
      reboot_q <= reboot_d;
      off_q    <= off_d;
      wake_q   <= wake_d;
      sreset_q <= sreset_d;
    end
  end

  assign sts_o           = sts_q;
  assign sts_next_o      = sts_d;
  assign run_o           = (state_q == ST_HBEAT);
  assign reboot_req_o    = reboot_q;
  assign soft_off_req_o  = off_q;
  assign wake_req_o      = wake_q;
  assign sys_reset_req_o = sreset_q;
endmodule

// File: rtl/wdt_recovery_ctrl.sv
module wdt_recovery_ctrl #(
  parameter int HB_TICKS = 31,
  parameter int SEQ_W    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reboot_policy_i,
  input  logic             wdt_expire_i,
  input  logic             tick_i,
  input  logic             sts_clr_i,
  input  logic             pb_override_i,
  input  logic             pb_press_i,
  input  logic             pwr_good_i,
  input  logic             bus_rst_cmd_i,
  input  logic             msg_ready_i,
  output logic             sts_o,
  output logic             reboot_req_o,
  output logic             soft_off_req_o,
  output logic             wake_req_o,
  output logic             sys_reset_req_o,
  output logic             msg_valid_o,
  output logic             msg_kind_o,
  output logic             msg_wd_evt_o,
  output logic [SEQ_W-1:0] msg_seq_o
);
  logic rst_evt, due, run, alert, hb, flush, sts_next;

  wdr_event_in u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pwr_good_i   (pwr_good_i),
    .bus_rst_cmd_i(bus_rst_cmd_i),
    .rst_evt_o    (rst_evt)
  );

  wdr_hb_timer #(.HB_TICKS(HB_TICKS)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_i(tick_i),
    .due_o (due)
  );

  wdr_policy_fsm u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .reboot_policy_i(reboot_policy_i),
    .expire_i       (wdt_expire_i),
    .clr_i          (sts_clr_i),
    .override_i     (pb_override_i),
    .press_i        (pb_press_i),
    .rst_evt_i      (rst_evt),
    .due_i          (due),
    .sts_o          (sts_o),
    .sts_next_o     (sts_next),
    .run_o          (run),
    .alert_o        (alert),
    .hb_o           (hb),
    .flush_o        (flush),
    .reboot_req_o   (reboot_req_o),
    .soft_off_req_o (soft_off_req_o),
    .wake_req_o     (wake_req_o),
    .sys_reset_req_o(sys_reset_req_o)
  );

  wdr_msg_queue #(.SEQ_W(SEQ_W)) u_msg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .alert_i   (alert),
    .hb_i      (hb),
    .flush_hb_i(flush),
    .wd_evt_i  (sts_next),
    .ready_i   (msg_ready_i),
    .valid_o   (msg_valid_o),
    .kind_o    (msg_kind_o),
    .wd_evt_o  (msg_wd_evt_o),
    .seq_o     (msg_seq_o)
  );
endmodule

// File: rtl/wdt_recovery_ctrl_chk.sv
module wdt_recovery_ctrl_chk #(
  parameter int SEQ_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wdt_expire_i,
  input logic             sts_clr_i,
  input logic             msg_ready_i,
  input logic             sts_o,
  input logic             reboot_req_o,
  input logic             soft_off_req_o,
  input logic             wake_req_o,
  input logic             sys_reset_req_o,
  input logic             msg_valid_o,
  input logic             msg_kind_o,
  input logic [SEQ_W-1:0] msg_seq_o
);
  a_r2_sts_set_by_expire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_o) |-> $past(wdt_expire_i));

  a_r10_sts_clr_by_fw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_o) |-> $past(sts_clr_i));

  a_r3_reboot_with_lockup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reboot_req_o |-> $rose(sts_o));

  a_r12_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_seq_o) && $stable(msg_kind_o)));

  a_r11_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(msg_seq_o) |-> (msg_valid_o && msg_seq_o == SEQ_W'($past(msg_seq_o) + 1'b1)));

  a_r13_req_needs_sts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_off_req_o || wake_req_o || sys_reset_req_o) |-> sts_o);

  a_r9_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reboot_req_o, soft_off_req_o, wake_req_o, sys_reset_req_o}));
endmodule

bind wdt_recovery_ctrl wdt_recovery_ctrl_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wdt_expire_i   (wdt_expire_i),
  .sts_clr_i      (sts_clr_i),
  .msg_ready_i    (msg_ready_i),
  .sts_o          (sts_o),
  .reboot_req_o   (reboot_req_o),
  .soft_off_req_o (soft_off_req_o),
  .wake_req_o     (wake_req_o),
  .sys_reset_req_o(sys_reset_req_o),
  .msg_valid_o    (msg_valid_o),
  .msg_kind_o     (msg_kind_o),
  .msg_seq_o      (msg_seq_o)
);

// File: tb/wdt_recovery_ctrl_tb.sv
module wdt_recovery_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 4;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic policy = 1'b0, expire = 1'b0, tick = 1'b0, clr = 1'b0;
  logic ovr = 1'b0, press = 1'b0, pgood = 1'b1, bcmd = 1'b0, ready = 1'b1;
  logic sts, reboot, soft_off, wake, sreset, valid, kind, wdevt;
  logic [SW-1:0] seq;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_recovery_ctrl #(.HB_TICKS(HB), .SEQ_W(SW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reboot_policy_i(policy), .wdt_expire_i(expire),
    .tick_i(tick), .sts_clr_i(clr), .pb_override_i(ovr), .pb_press_i(press),
    .pwr_good_i(pgood), .bus_rst_cmd_i(bcmd), .msg_ready_i(ready),
    .sts_o(sts), .reboot_req_o(reboot), .soft_off_req_o(soft_off), .wake_req_o(wake),
    .sys_reset_req_o(sreset), .msg_valid_o(valid), .msg_kind_o(kind),
    .msg_wd_evt_o(wdevt), .msg_seq_o(seq)
  );

  int n_chk = 0, n_bad = 0;
  int tick_r = 1, tick_div = 0, cyc = 0;
  int n_acc = 0, n_hb = 0, n_reboot = 0, n_off = 0, n_wake = 0, n_rst = 0;
  int last_seq = 0, prev_hb = 0, gap_exp = HB;
  bit have_prev = 0, gap_en = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    tick_div++;
    tick = (tick_r != 0) && (tick_div % tick_r == 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // monitor at the falling edge, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (reboot)   n_reboot++;
      if (soft_off) n_off++;
      if (wake)     n_wake++;
      if (sreset)   n_rst++;
      if (valid && ready) begin
        n_acc++;
        chk(int'(seq) == (last_seq + 1) % (1 << SW), "R11 seq step", int'(seq), (last_seq + 1) % (1 << SW));
        chk(wdevt == 1'b1, "R14 wd event bit", int'(wdevt), 1);
        last_seq = int'(seq);
        if (kind) begin
          n_hb++;
          if (gap_en) begin
            if (have_prev) chk(cyc - prev_hb == gap_exp, "R5 heartbeat period", cyc - prev_hb, gap_exp);
            have_prev = 1;
            prev_hb = cyc;
          end
        end
      end
      if (!gap_en) have_prev = 0;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int a0, h0, r0, o0, w0, s0, sq;
    run(3);
    chk(!sts && !valid && seq == 0, "R1 reset outputs", int'({sts, valid, seq}), 0);
    rst_n = 1'b1;
    step();
    chk(!sts && !valid && !reboot && !soft_off && !wake && !sreset, "R1 after release", int'({sts, valid, reboot, soft_off, wake, sreset}), 0);

    // R13: interventions while idle
    a0 = n_acc; o0 = n_off; w0 = n_wake; s0 = n_rst;
    ovr = 1; step(); ovr = 0; press = 1; step(); press = 0;
    bcmd = 1; step(); bcmd = 0; pgood = 0; run(2); pgood = 1; run(3);
    chk(n_off == o0 && n_wake == w0 && n_rst == s0 && n_acc == a0, "R13 idle events ignored", n_off + n_wake + n_rst + n_acc - o0 - w0 - s0 - a0, 0);

    // reboot policy, recovered
    policy = 1; r0 = n_reboot;
    expire = 1; step(); expire = 0;
    chk(sts == 1, "R2 sts set", int'(sts), 1);
    chk(reboot == 1 && valid && kind == 0, "R3 reboot and alert", int'({reboot, valid, kind}), 6);
    run(5);
    chk(n_reboot - r0 == 1, "R3 single reboot", n_reboot - r0, 1);
    a0 = n_acc;
    clr = 1; step(); clr = 0;
    chk(sts == 0, "R4 sts cleared", int'(sts), 0);
    run(4 * HB);
    chk(n_acc == a0, "R4 no heartbeat after recovery", n_acc - a0, 0);

    // reboot policy, failed reboot, tick spacing sweep
    r0 = n_reboot;
    expire = 1; step(); expire = 0; run(3);
    expire = 1; step(); expire = 0;
    chk(valid && kind == 1 && !reboot, "R5 heartbeat on second expiry", int'({valid, kind, reboot}), 6);
    for (int r = 1; r <= 3; r++) begin
      tick_r = r; gap_exp = HB * r; gap_en = 0;
      run(HB * r + 2);
      h0 = n_hb; gap_en = 1;
      run(3 * HB * r + 1);
      chk(n_hb - h0 >= 3, "R5 heartbeats keep coming", n_hb - h0, 3);
      gap_en = 0;
    end
    tick_r = 1; gap_exp = HB;
    expire = 1; step(); expire = 0; run(2);
    chk(n_reboot - r0 == 1 && sts, "R5 no reboot on later expiry", n_reboot - r0, 1);

    // interventions in heartbeat mode
    run(HB + 2); gap_en = 1; h0 = n_hb;
    o0 = n_off; w0 = n_wake; s0 = n_rst;
    press = 1; step(); press = 0; run(1);
    chk(n_wake == w0, "R8 press without override ignored", n_wake - w0, 0);
    ovr = 1; step(); ovr = 0;
    chk(soft_off == 1, "R7 soft-off request", int'(soft_off), 1);
    run(2);
    press = 1; step(); press = 0;
    chk(wake == 1, "R8 wake after override", int'(wake), 1);
    press = 1; step(); press = 0; run(1);
    chk(n_wake - w0 == 1 && n_off - o0 == 1, "R8 single wake", n_wake - w0, 1);
    pgood = 0; run(3); pgood = 1; run(2);
    chk(n_rst - s0 == 1, "R9 power-good fall reset", n_rst - s0, 1);
    bcmd = 1; step(); bcmd = 0;
    chk(sreset == 1, "R9 bus reset command", int'(sreset), 1);
    run(4 * HB);
    chk(n_hb - h0 >= 4, "R7 heartbeats through interventions", n_hb - h0, 4);
    chk(sts == 1 && n_reboot - r0 == 1, "R2 sts sticky and R9 no reboot", int'(sts), 1);
    gap_en = 0;

    // R12 back-pressure and merge
    ready = 0; run(3 * HB + 1);
    sq = int'(seq);
    chk(valid == 1, "R12 valid held", int'(valid), 1);
    tick_r = 0; run(1);
    chk(int'(seq) == sq, "R12 seq held", int'(seq), sq);
    a0 = n_acc;
    ready = 1; run(4);
    chk(n_acc - a0 == 2, "R12 merged heartbeat count", n_acc - a0, 2);
    tick_r = 1; run(2 * HB);

    // R10 clear in heartbeat mode
    clr = 1; step(); clr = 0; run(1);
    a0 = n_acc;
    chk(sts == 0, "R10 sts cleared", int'(sts), 0);
    run(4 * HB);
    chk(n_acc == a0, "R10 heartbeats stop", n_acc - a0, 0);

    // R6 no-reboot policy
    policy = 0; r0 = n_reboot;
    expire = 1; step(); expire = 0;
    chk(valid && kind == 0 && !reboot && sts, "R6 immediate alert", int'({valid, kind, reboot, sts}), 9);
    run(HB + 2); gap_en = 1; h0 = n_hb;
    run(3 * HB + 1);
    chk(n_hb - h0 >= 3 && n_reboot == r0, "R6 heartbeats without reboot", n_hb - h0, 3);
    gap_en = 0;
    chk(n_acc > (1 << SW), "R11 sequence wrapped", n_acc, (1 << SW) + 1);
    clr = 1; step(); clr = 0; run(3);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule